// File: doc/BRIEF.md
# MDIO Management Master with Command and Data Registers

This block manages external PHY devices over a two-wire management bus (IEEE 802.3 Clause 22). Software sees two 32-bit registers through a simple write strobe and a combinational read port. One register holds the command word. The other holds a 16-bit data value. Software first stages the data, if there is any to send. It then writes the command word with its busy bit set. The block runs one complete read or write frame on the management clock and data lines, and it clears the busy bit when the frame ends. Software polls the busy bit. Once busy reads 0, the value read from the PHY is in the data register.

The management clock is derived from the system clock. A 4-bit range code in each command selects the divisor. A command written with the busy bit clear starts no frame. It still produces exactly one management clock period, with the data line released, so that a PHY that needs clock edges to leave reset can complete it.

Top module: `mdio_regmaster`

## Requirements
- R1: After synchronous reset, the command and data registers read 0, `mdc` is low and `mdio_oe` is low.
- R2: A write to the command register (`reg_sel`=0) with bit 0 set starts a frame. Bit 0 reads back as 1 while the frame runs and returns to 0 after the 64th MDC period.
- R3: A write frame (command bit 1 = 1) carries these bits on successive rising MDC edges, all with `mdio_oe` high:
  - 32 ones
  - 01
  - opcode 01
  - the PHY address, MSB first, from command bits 15:11
  - the register number, MSB first, from command bits 10:6
  - turnaround 10
  - the 16 data-register bits, MSB first
- R4: A read frame (command bit 1 = 0) uses opcode 10. `mdio_oe` is high for the first 46 bits and low for the last 18. The 16 bits that the PHY presents before each rising MDC edge of bits 48 to 63 are stored MSB first in the data register by the time busy reads 0.
- R5: Command bits 5:2 select the MDC period in system clocks. The codes map as follows:

  | Code | Period |
  |------|--------|
  | 0 | 42 |
  | 1 | 62 |
  | 2 | 16 |
  | 3 | 26 |
  | 4 | 102 |
  | 5 | 124 |
  | any other | 42 |

- R6: Each MDC period begins low for half the period and then stays high for the other half. MDC is low whenever no frame or single clock period is running.
- R7: A command write with bit 0 clear produces exactly one MDC period. During it `mdio_oe` stays low and busy reads 0.
- R8: While busy is 1, writes to either register are ignored. A write frame sends the data register value held when the frame started.
- R9: `reg_sel`=0 reads the command register and `reg_sel`=1 reads the data register. Bits 31:16 of both registers read 0, and bits 31:16 of writes are discarded.
- R10: `mdio_o` changes only while `mdc` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 command, 1 data |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data in |

## Verification
The bench contains a PHY model that records every bit and its output-enable value on rising MDC edges, and that drives read data after falling edges. The checks target four kinds of fault:
- An off-by-one in the bit sequence, which would shift the address or data fields of the captured frame.
- Releasing MDIO at the wrong bit, which would show as a wrong output-enable map.
- Sampling read data on the wrong edge, which would return a value rotated by one bit.
- Ignoring the busy lock, which would let a write made mid-frame change the registers or the data being sent.

The clock-divisor table is measured code by code as low and high time in system clocks. The all-zero command write is watched for exactly one MDC rise with MDIO never driven.

// File: rtl/mdio_rm_pkg.sv
package mdio_rm_pkg;

    localparam int REG_W      = 32;
    localparam int DATA_W     = 16;
    localparam int FLD_W      = 5;
    localparam int CODE_W     = 4;
    localparam int DIV_W      = 7;
    localparam int PRE_BITS   = 32;
    localparam int FRAME_BITS = 64;
    localparam int HDR_BITS   = 46;
    localparam int RD_FIRST   = 48;
    localparam int TX_W       = FRAME_BITS - PRE_BITS;
    localparam int BIT_W      = $clog2(FRAME_BITS);

    localparam logic SEL_CMD  = 1'b0;
    localparam logic SEL_DATA = 1'b1;

    // Command word layout, MSB down to LSB
    typedef struct packed {
        logic [FLD_W-1:0]  phy_addr;
        logic [FLD_W-1:0]  reg_num;
        logic [CODE_W-1:0] clk_code;
        logic              is_write;
        logic              busy;
    } cmd_t;

    typedef enum logic [1:0] {
        ENG_IDLE  = 2'd0,
        ENG_FRAME = 2'd1,
        ENG_PULSE = 2'd2
    } eng_state_e;

    function automatic logic [DIV_W-1:0] code_to_div(input logic [CODE_W-1:0] code);
        case (code)
            4'd1:    return 7'd62;
            4'd2:    return 7'd16;
            4'd3:    return 7'd26;
            4'd4:    return 7'd102;
            4'd5:    return 7'd124;
            default: return 7'd42;
        endcase
    endfunction

    // Everything after the preamble: start, opcode, addresses, turnaround, payload
    function automatic logic [TX_W-1:0] frame_body(input cmd_t c, input logic [DATA_W-1:0] d);
        logic [1:0]        op;
        logic [1:0]        ta;
        logic [DATA_W-1:0] pay;
        op  = c.is_write ? 2'b01 : 2'b10;
        ta  = c.is_write ? 2'b10 : 2'b00;
        pay = c.is_write ? d : '0;
        return {2'b01, op, c.phy_addr, c.reg_num, ta, pay};
    endfunction

endpackage

// File: rtl/mdio_rm_clkdiv.sv
module mdio_rm_clkdiv
    import mdio_rm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             mdc,
    output logic             rise_stb,
    output logic             fall_stb
);

    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] half_m1;
    logic [DIV_W-1:0] full_m1;

    assign half_m1 = (div >> 1) - DIV_W'(1);
    assign full_m1 = div - DIV_W'(1);

    always_comb begin
        rise_stb = run && !restart && (cnt == half_m1);
        fall_stb = run && !restart && (cnt == full_m1);
    end

    always_ff @(posedge clk) begin
        if (rst || restart || !run) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (fall_stb) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else begin
            cnt <= cnt + DIV_W'(1);
            if (rise_stb) begin
                mdc <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/mdio_rm_engine.sv
module mdio_rm_engine
    import mdio_rm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start_frame,
    input  logic              start_pulse,
    input  cmd_t              start_cmd,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              rise_stb,
    input  logic              fall_stb,
    input  logic              mdio_i,
    output logic              run,
    output logic [DIV_W-1:0]  div,
    output logic              mdio_o,
    output logic              mdio_oe,
    output logic              done,
    output logic              rx_valid,
    output logic [DATA_W-1:0] rx_data
);

    localparam logic [BIT_W-1:0] IDX_LAST = BIT_W'(FRAME_BITS - 1);
    localparam logic [BIT_W-1:0] IDX_PRE  = BIT_W'(PRE_BITS);
    localparam logic [BIT_W-1:0] IDX_HDR  = BIT_W'(HDR_BITS);
    localparam logic [BIT_W-1:0] IDX_RD   = BIT_W'(RD_FIRST);

    eng_state_e        st;
    logic [BIT_W-1:0]  bit_idx;
    logic [BIT_W-1:0]  nxt_idx;
    logic [TX_W-1:0]   sh;
    logic [DATA_W-1:0] rx_sh;
    logic              wr_q;
    logic [DIV_W-1:0]  div_q;
    logic              o_q;
    logic              oe_q;
    logic              last_bit;

    always_comb begin
        nxt_idx  = bit_idx + BIT_W'(1);
        last_bit = (st == ENG_FRAME) && fall_stb && (bit_idx == IDX_LAST);
        done     = last_bit;
        rx_valid = last_bit && !wr_q;
        rx_data  = rx_sh;
        run      = (st != ENG_IDLE);
        div      = div_q;
        mdio_o   = o_q;
        mdio_oe  = oe_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ENG_IDLE;
            bit_idx <= '0;
            sh      <= '0;
            rx_sh   <= '0;
            wr_q    <= 1'b0;
            div_q   <= code_to_div('0);
            o_q     <= 1'b0;
            oe_q    <= 1'b0;
        end else if (start_frame) begin
            st      <= ENG_FRAME;
            bit_idx <= '0;
            sh      <= frame_body(start_cmd, tx_data);
            rx_sh   <= '0;
            wr_q    <= start_cmd.is_write;
            div_q   <= code_to_div(start_cmd.clk_code);
            o_q     <= 1'b1;
            oe_q    <= 1'b1;
        end else if (start_pulse) begin
            st      <= ENG_PULSE;
            bit_idx <= '0;
            div_q   <= code_to_div(start_cmd.clk_code);
            o_q     <= 1'b0;
            oe_q    <= 1'b0;
        end else begin
            case (st)
                ENG_FRAME: begin
                    if (rise_stb && !wr_q && (bit_idx >= IDX_RD)) begin
                        rx_sh <= {rx_sh[DATA_W-2:0], mdio_i};
                    end
                    if (fall_stb) begin
                        if (bit_idx == IDX_LAST) begin
                            st   <= ENG_IDLE;
                            o_q  <= 1'b0;
                            oe_q <= 1'b0;
                        end else begin
                            bit_idx <= nxt_idx;
                            if (nxt_idx >= IDX_PRE) begin
                                o_q <= sh[TX_W-1];
                                sh  <= {sh[TX_W-2:0], 1'b0};
                            end else begin
                                o_q <= 1'b1;
                            end
                            oe_q <= wr_q || (nxt_idx < IDX_HDR);
                        end
                    end
                end
                ENG_PULSE: begin
                    if (fall_stb) begin
                        st <= ENG_IDLE;
                    end
                end
                default: begin
                end
            endcase
        end
    end

endmodule

// File: rtl/mdio_rm_regs.sv
module mdio_rm_regs
    import mdio_rm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic              sel,
    input  logic [DATA_W-1:0] wdata,
    input  logic              done,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_data,
    output cmd_t              cmd_q,
    output logic [DATA_W-1:0] data_q,
    output logic              start_frame,
    output logic              start_pulse,
    output cmd_t              start_cmd,
    output logic [REG_W-1:0]  rdata
);

    logic accept;

    always_comb begin
        accept      = we && !cmd_q.busy;
        start_cmd   = cmd_t'(wdata);
        start_frame = accept && (sel == SEL_CMD) && wdata[0];
        start_pulse = accept && (sel == SEL_CMD) && !wdata[0];
        rdata       = (sel == SEL_DATA) ? {{(REG_W-DATA_W){1'b0}}, data_q}
                                        : {{(REG_W-DATA_W){1'b0}}, cmd_q};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q  <= '0;
            data_q <= '0;
        end else begin
            if (accept && (sel == SEL_CMD)) begin
                cmd_q <= cmd_t'(wdata);
            end
            if (accept && (sel == SEL_DATA)) begin
                data_q <= wdata;
            end
            if (done) begin
                cmd_q.busy <= 1'b0;
            end
            if (rx_valid) begin
                data_q <= rx_data;
            end
        end
    end

endmodule

// File: rtl/mdio_regmaster.sv
module mdio_regmaster
    import mdio_rm_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_we,
    input  logic        reg_sel,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);

    cmd_t              cmd_word;
    cmd_t              start_cmd;
    logic [DATA_W-1:0] data_word;
    logic              start_frame;
    logic              start_pulse;
    logic              eng_done;
    logic              rx_valid;
    logic [DATA_W-1:0] rx_data;
    logic              run;
    logic [DIV_W-1:0]  div;
    logic              rise_stb;
    logic              fall_stb;
    logic              unused_upper;

    assign unused_upper = ^reg_wdata[REG_W-1:DATA_W];

    mdio_rm_regs u_regs (
        .clk         (clk),
        .rst         (rst),
        .we          (reg_we),
        .sel         (reg_sel),
        .wdata       (reg_wdata[DATA_W-1:0]),
        .done        (eng_done),
        .rx_valid    (rx_valid),
        .rx_data     (rx_data),
        .cmd_q       (cmd_word),
        .data_q      (data_word),
        .start_frame (start_frame),
        .start_pulse (start_pulse),
        .start_cmd   (start_cmd),
        .rdata       (reg_rdata)
    );

    mdio_rm_engine u_engine (
        .clk         (clk),
        .rst         (rst),
        .start_frame (start_frame),
        .start_pulse (start_pulse),
        .start_cmd   (start_cmd),
        .tx_data     (data_word),
        .rise_stb    (rise_stb),
        .fall_stb    (fall_stb),
        .mdio_i      (mdio_i),
        .run         (run),
        .div         (div),
        .mdio_o      (mdio_o),
        .mdio_oe     (mdio_oe),
        .done        (eng_done),
        .rx_valid    (rx_valid),
        .rx_data     (rx_data)
    );

    mdio_rm_clkdiv u_clkdiv (
        .clk      (clk),
        .rst      (rst),
        .restart  (start_frame || start_pulse),
        .run      (run),
        .div      (div),
        .mdc      (mdc),
        .rise_stb (rise_stb),
        .fall_stb (fall_stb)
    );

endmodule

// File: rtl/mdio_regmaster_chk.sv
module mdio_regmaster_chk (
    input logic        clk,
    input logic        rst,
    input logic        reg_we,
    input logic        reg_sel,
    input logic        wbit0,
    input logic        mdc,
    input logic        mdio_o,
    input logic        mdio_oe,
    input logic        busy,
    input logic [14:0] cmd_hi,
    input logic [15:0] data_bits
);

    logic [7:0] lvl_cnt;
    logic       mdc_d;

    always_ff @(posedge clk) begin
        if (rst || !busy || (mdc != mdc_d)) begin
            lvl_cnt <= '0;
        end else if (lvl_cnt != 8'hFF) begin
            lvl_cnt <= lvl_cnt + 8'd1;
        end
        mdc_d <= mdc;
    end

    AST_BUSY_SET: assert property (@(posedge clk) disable iff (rst)
        (reg_we && !reg_sel && wbit0 && !busy) |=> busy); // R2

    AST_CMD_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(cmd_hi)); // R8

    AST_DATA_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(data_bits)); // R8

    AST_OE_IDLE: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mdio_oe); // R7

    AST_MDIO_SETUP: assert property (@(posedge clk) disable iff (rst)
        !$stable(mdio_o) |-> !mdc); // R10

    AST_HALF_BOUND: assert property (@(posedge clk) disable iff (rst)
        busy |-> (lvl_cnt <= 8'd63)); // R6

endmodule

bind mdio_regmaster mdio_regmaster_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_we    (reg_we),
    .reg_sel   (reg_sel),
    .wbit0     (reg_wdata[0]),
    .mdc       (mdc),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe),
    .busy      (cmd_word.busy),
    .cmd_hi    (cmd_word[15:1]),
    .data_bits (data_word)
);

// File: tb/mdio_regmaster_tb.sv
module mdio_regmaster_tb;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic        reg_sel = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mdc;
    logic        mdio_o;
    logic        mdio_oe;
    logic        mdio_i = 1'b1;

    int total = 0;
    int bad = 0;

    int          rise_n = 0;
    int          fall_n = 0;
    logic [63:0] cap = '0;
    logic [63:0] oe_map = '0;
    logic [15:0] phy_val = '0;
    int          oe_seen = 0;
    int          edge_bad = 0;
    logic        prev_o = 1'b0;
    logic        prev_mdc = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    mdio_regmaster u_dut (
        .clk       (clk),
        .rst       (rst),
        .reg_we    (reg_we),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .mdc       (mdc),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe),
        .mdio_i    (mdio_i)
    );

    // PHY model: capture on rising MDC, present read data after falling MDC
    always @(posedge mdc) begin
        if (rise_n < 64) begin
            cap[63-rise_n]    = mdio_o;
            oe_map[63-rise_n] = mdio_oe;
        end
        rise_n++;
    end

    always @(negedge mdc) begin
        fall_n++;
        if (fall_n >= 48 && fall_n <= 63) mdio_i = phy_val[63-fall_n];
        else if (fall_n == 47)            mdio_i = 1'b0;
        else                              mdio_i = 1'b1;
    end

    always @(negedge clk) begin
        if (!rst) begin
            if (mdio_oe === 1'b1) oe_seen++;
            if (mdio_o !== prev_o && mdc === 1'b1 && prev_mdc === 1'b1) edge_bad++;
        end
        prev_o   = mdio_o;
        prev_mdc = mdc;
    end

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic sel, input logic [31:0] v);
        @(negedge clk);
        reg_we    = 1'b1;
        reg_sel   = sel;
        reg_wdata = v;
        @(negedge clk);
        reg_we    = 1'b0;
    endtask

    task automatic rd_reg(input logic sel, output logic [31:0] v);
        reg_sel = sel;
        #1;
        v = reg_rdata;
    endtask

    task automatic wait_idle(output bit ok);
        logic [31:0] v;
        ok = 1'b0;
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            rd_reg(1'b0, v);
            if (!v[0]) begin
                ok = 1'b1;
                break;
            end
        end
    endtask

    task automatic clear_mon();
        rise_n  = 0;
        fall_n  = 0;
        cap     = '0;
        oe_map  = '0;
        oe_seen = 0;
    endtask

    function automatic logic [31:0] cmd_of(input logic [4:0] phy, input logic [4:0] rn,
                                           input logic [3:0] code, input logic wr, input logic go);
        return {16'h0, phy, rn, code, wr, go};
    endfunction

    function automatic int exp_div(input int code);
        case (code)
            1:       return 62;
            2:       return 16;
            3:       return 26;
            4:       return 102;
            5:       return 124;
            default: return 42;
        endcase
    endfunction

    task automatic t_reset();
        logic [31:0] v;
        @(negedge clk);
        rd_reg(1'b0, v);
        check(v == 0, "R1 cmd after reset", v, 0);
        rd_reg(1'b1, v);
        check(v == 0, "R1 data after reset", v, 0);
        check(mdc == 1'b0, "R1 mdc low", mdc, 0);
        check(mdio_oe == 1'b0, "R1 oe low", mdio_oe, 0);
    endtask

    task automatic t_write();
        logic [31:0] v;
        logic [31:0] c;
        logic [63:0] e;
        bit          ok;
        c = cmd_of(5'h11, 5'h0A, 4'd2, 1'b1, 1'b1);
        wr_reg(1'b1, 32'h0000_A5C3);
        clear_mon();
        wr_reg(1'b0, c);
        rd_reg(1'b0, v);
        check(v == c, "R2 busy reads 1 during frame", v, c);
        wait_idle(ok);
        check(ok, "R2 busy clears", ok, 1);
        check(rise_n == 64, "R2 64 MDC periods", rise_n, 64);
        e = {32'hFFFF_FFFF, 2'b01, 2'b01, 5'h11, 5'h0A, 2'b10, 16'hA5C3};
        check(cap == e, "R3 write frame bits", cap, e);
        check(oe_map == '1, "R3 oe high whole write", oe_map, '1);
        rd_reg(1'b0, v);
        check(v == (c & ~32'h1), "R2 cmd after write", v, c & ~32'h1);
    endtask

    task automatic t_read();
        logic [31:0] v;
        logic [45:0] eh;
        logic [63:0] eo;
        bit          ok;
        phy_val = 16'hB2C1;
        clear_mon();
        wr_reg(1'b0, cmd_of(5'h03, 5'h01, 4'd3, 1'b0, 1'b1));
        wait_idle(ok);
        check(ok, "R4 read completes", ok, 1);
        eh = {32'hFFFF_FFFF, 2'b01, 2'b10, 5'h03, 5'h01};
        check(cap[63:18] == eh, "R4 read header", cap[63:18], eh);
        eo = {{46{1'b1}}, 18'b0};
        check(oe_map == eo, "R4 oe release", oe_map, eo);
        rd_reg(1'b1, v);
        check(v == 32'h0000_B2C1, "R4 read data", v, 32'h0000_B2C1);
    endtask

    task automatic t_clock();
        int codes[9] = '{0, 1, 2, 3, 4, 5, 6, 7, 15};
        foreach (codes[k]) begin
            int lo;
            int hi;
            int d;
            d  = exp_div(codes[k]);
            lo = 0;
            hi = 0;
            clear_mon();
            wr_reg(1'b0, cmd_of(5'h0, 5'h0, 4'(codes[k]), 1'b0, 1'b0));
            while (mdc === 1'b0 && lo < 500) begin lo++; @(negedge clk); end
            while (mdc === 1'b1 && hi < 500) begin hi++; @(negedge clk); end
            check(lo + hi == d, "R5 MDC period", lo + hi, d);
            check(lo == d / 2 && hi == d / 2, "R6 half periods", {lo[31:0], hi[31:0]}, {d / 2, d / 2});
            repeat (150) @(negedge clk);
            check(rise_n == 1, "R7 one MDC per idle write", rise_n, 1);
        end
    endtask

    task automatic t_dummy();
        logic [31:0] v;
        clear_mon();
        wr_reg(1'b0, 32'hFFFF_0000);
        rd_reg(1'b0, v);
        check(v == 0, "R7 busy stays 0 / R9 upper zero", v, 0);
        repeat (200) @(negedge clk);
        check(rise_n == 1 && fall_n == 1, "R7 exactly one MDC period", {rise_n[31:0], fall_n[31:0]}, {32'd1, 32'd1});
        check(oe_seen == 0, "R7 mdio never driven", oe_seen, 0);
    endtask

    task automatic t_ignore();
        logic [31:0] v;
        logic [31:0] c;
        bit          ok;
        c = cmd_of(5'h1F, 5'h00, 4'd2, 1'b1, 1'b1);
        wr_reg(1'b1, 32'h0000_1234);
        clear_mon();
        wr_reg(1'b0, c);
        wr_reg(1'b1, 32'h0000_FFFF);
        wr_reg(1'b0, 32'h0000_F7FE);
        rd_reg(1'b1, v);
        check(v == 32'h1234, "R8 data write ignored", v, 32'h1234);
        rd_reg(1'b0, v);
        check(v == c, "R8 cmd write ignored", v, c);
        wait_idle(ok);
        check(cap[15:0] == 16'h1234, "R8 frame sends start data", cap[15:0], 16'h1234);
        rd_reg(1'b0, v);
        check(v == (c & ~32'h1), "R8 cmd after frame", v, c & ~32'h1);
        repeat (300) @(negedge clk);
        check(rise_n == 64, "R8 no extra activity", rise_n, 64);
    endtask

    task automatic t_upper();
        logic [31:0] v;
        wr_reg(1'b1, 32'hFFFF_0F0F);
        rd_reg(1'b1, v);
        check(v == 32'h0000_0F0F, "R9 data upper bits zero", v, 32'h0000_0F0F);
    endtask

    initial begin
        #(CLK_P * 200000);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst = 1'b1;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_write();
        t_read();
        t_clock();
        t_dummy();
        t_ignore();
        t_upper();
        check(edge_bad == 0, "R10 mdio stable while mdc high", edge_bad, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule